// File: doc/BRIEF.md
# VLIW Multithread Issue-Slot Merger

This block sits in the decode stage of a five-stage multithreaded VLIW pipeline (fetch, decode/merge, operand read, execute, write-back). Every cycle each hardware thread context offers one candidate MultiOp. The merger builds one issue bundle from these offers. Thread 0 is the main thread and always claims slots first. The speculative threads, in ascending index order, then fill whatever slots the main thread's compiled schedule left empty. A stalled main thread, for example one waiting on a cache miss, drops out for that cycle, so the speculative threads can use the whole bundle.

Each issue slot serves one functional-unit type. Each operation carries a type tag and lands in the lowest-numbered free slot of its type. A MultiOp marked inseparable issues only when every one of its outstanding operations fits in the same cycle. A separable MultiOp may issue part of its operations now. A per-thread residual mask then holds the operations that have not issued yet, and only those are offered in later cycles. Each slot of the bundle carries the ID of its source thread, so that later stages use the right register file. Per-thread acknowledgements tell fetch when a MultiOp is fully consumed or only partly issued. The `ALLOW_SPLIT` parameter can turn off separable handling, so that every MultiOp is then treated as inseparable.

Top module: `mtw_issue_merger`

## Requirements
- R1: Thread 0 (main) is placed first, and its operations receive slots exactly as if no other thread were present.
- R2: Speculative threads 1..N-1 are placed in ascending index order, each one seeing only the slots left free by all lower-indexed threads; when two threads want the only slot of a type, the lower index wins.
- R3: A thread whose valid is low or whose stall is high issues nothing and gets no acknowledgement; its slots become available to the other threads in that cycle.
- R4: An operation goes only to a slot whose type equals its 2-bit type tag, and it goes to the lowest-indexed free slot of that type. With the default map, slots 0 and 1 are type 0, slot 2 is type 1 and slot 3 is type 2. Operation j of thread t uses mask bit t*4+j.
- R5: An inseparable MultiOp (separable bit 0) whose outstanding operations do not all fit issues none of them, asserts neither acknowledgement, and leaves its slots to the threads that follow it.
- R6: A separable MultiOp (separable bit 1) that fits only in part issues the operations that fit and asserts partial (not done). In later cycles only its remaining operations are offered, and done rises once they have all issued.
- R7: Every valid slot of the bundle carries the index of the thread that supplied its operation.
- R8: The done and partial acknowledgements are combinational in the offer cycle, and the bundle appears at the outputs one clock edge after that offer.
- R9: During and after reset the bundle is empty and all residual masks are cleared, so the first offer after reset is taken whole.
- R10: A cycle in which a thread's valid is low discards that thread's residual mask, so its next offer is taken whole.
- R11: A valid, unstalled MultiOp with an empty operation mask is acknowledged as done at once and takes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_valid | input | NT | A MultiOp is offered by thread t |
| thr_stall | input | NT | Thread t is stalled this cycle |
| thr_sep | input | NT | MultiOp of thread t is separable |
| thr_opmask | input | NT*W | Operation present, bit t*W+j |
| thr_optype | input | NT*W*TW | Functional-unit type of each operation |
| thr_oppay | input | NT*W*PW | Payload of each operation |
| thr_done | output | NT | MultiOp of thread t fully issued this cycle |
| thr_part | output | NT | MultiOp of thread t partly issued, rest held |
| iss_valid | output | W | Bundle slot holds an operation |
| iss_pay | output | W*PW | Payload per bundle slot |
| iss_tid | output | W*TIDW | Source thread per bundle slot |

## Verification
The acknowledgements are combinational, so the bench reads them 1 ns after it drives an offer on the falling edge, before the next rising edge. At that same point it confirms that the bundle still shows the previous cycle. The bundle goes through one register, so the bench checks it on the falling edge after the rising edge that captured it, which is the point where the next offer is driven. Residual behaviour spans two or three offer cycles. It is checked at the second offer, where only the operations still pending must appear, or, after a squash or reset, where all of them must.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
   // Upper bound used for elaboration checks on the issue width.
   localparam int MTW_MAX_SLOTS = 16;
   // Upper bound on thread contexts.
   localparam int MTW_MAX_THREADS = 16;

   // Default slot map: slot0,1 type 0; slot2 type 1; slot3 type 2.
   localparam logic [7:0] MTW_DEFAULT_MAP = 8'b10_01_00_00;
endpackage

// File: rtl/mtw_thread_alloc.sv
module mtw_thread_alloc #(
   parameter int W  = 4,
   parameter int TW = 2,
   parameter logic [W*TW-1:0] SLOT_MAP = '0
) (
   input  logic            eligible,
   input  logic            sep,
   input  logic [W-1:0]    pending,
   input  logic [W*TW-1:0] optype,
   input  logic [W-1:0]    free_in,
   output logic [W-1:0]    grant,
   output logic [W*W-1:0]  op_slot,
   output logic [W-1:0]    free_out,
   output logic            commit
);
   logic [W-1:0]   free_tmp;
   logic [W-1:0]   trial;
   logic [W*W-1:0] map;
   logic [W-1:0]   cand;
   logic [W-1:0]   pick;
   logic           fits;

   always_comb begin
      free_tmp = free_in;
      trial    = '0;
      map      = '0;
      cand     = '0;
      pick     = '0;
      for (int j = 0; j < W; j++) begin
         if (eligible && pending[j]) begin
            for (int s = 0; s < W; s++) begin
               cand[s] = free_tmp[s] &&
                         (SLOT_MAP[s*TW +: TW] == optype[j*TW +: TW]);
            end
            pick = cand & (~cand + 1'b1);
            if (pick != '0) begin
               map[j*W +: W] = pick;
               free_tmp      = free_tmp & ~pick;
               trial[j]      = 1'b1;
            end
         end
      end
      fits   = (trial == pending);
      commit = eligible && (sep || fits);
      grant    = commit ? trial : '0;
      op_slot  = commit ? map : '0;
      free_out = commit ? free_tmp : free_in;
   end
endmodule

// File: rtl/mtw_resid.sv
module mtw_resid #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid,
   input  logic [W-1:0] opmask,
   input  logic         commit,
   input  logic [W-1:0] grant,
   output logic [W-1:0] pending,
   output logic         done,
   output logic         part
);
   logic         act_q;
   logic [W-1:0] mask_q;

   assign pending = act_q ? mask_q : opmask;
   assign done    = commit && (grant == pending);
   assign part    = commit && (grant != '0) && (grant != pending);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         mask_q <= '0;
      end else if (!valid || done) begin
         act_q  <= 1'b0;
         mask_q <= '0;
      end else if (part) begin
         act_q  <= 1'b1;
         mask_q <= pending & ~grant;
      end
   end

   AST_DONE_PART_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && part)); // R6
   AST_RESID_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      part |=> (act_q && ((mask_q & ~$past(pending)) == '0) && (mask_q != '0))); // R6
   AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> !act_q); // R10
endmodule

// File: rtl/mtw_bundle_reg.sv
module mtw_bundle_reg #(
   parameter int W    = 4,
   parameter int PW   = 16,
   parameter int TIDW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    d_valid,
   input  logic [W*PW-1:0] d_pay,
   input  logic [W*TIDW-1:0] d_tid,
   output logic [W-1:0]    q_valid,
   output logic [W*PW-1:0] q_pay,
   output logic [W*TIDW-1:0] q_tid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= '0;
         q_pay   <= '0;
         q_tid   <= '0;
      end else begin
         q_valid <= d_valid;
         q_pay   <= d_pay;
         q_tid   <= d_tid;
      end
   end
endmodule

// File: rtl/mtw_issue_merger.sv
module mtw_issue_merger #(
   parameter int NT  = 4,
   parameter int W   = 4,
   parameter int TW  = 2,
   parameter int PW  = 16,
   parameter bit ALLOW_SPLIT = 1'b1,
   parameter logic [W*TW-1:0] SLOT_MAP = mtw_pkg::MTW_DEFAULT_MAP,
   localparam int TIDW = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      thr_valid,
   input  logic [NT-1:0]      thr_stall,
   input  logic [NT-1:0]      thr_sep,
   input  logic [NT*W-1:0]    thr_opmask,
   input  logic [NT*W*TW-1:0] thr_optype,
   input  logic [NT*W*PW-1:0] thr_oppay,
   output logic [NT-1:0]      thr_done,
   output logic [NT-1:0]      thr_part,
   output logic [W-1:0]       iss_valid,
   output logic [W*PW-1:0]    iss_pay,
   output logic [W*TIDW-1:0]  iss_tid
);
   generate
      if (NT < 2 || NT > mtw_pkg::MTW_MAX_THREADS) begin : g_bad_nt
         $error("mtw_issue_merger: NT out of range");
      end
      if (W < 1 || W > mtw_pkg::MTW_MAX_SLOTS) begin : g_bad_w
         $error("mtw_issue_merger: W out of range");
      end
      if (TW < 1 || PW < 1) begin : g_bad_tw
         $error("mtw_issue_merger: TW and PW must be positive");
      end
   endgenerate

   logic [NT-1:0] sep_eff;
   logic [NT-1:0] eligible;
   logic [W-1:0]  free_chain [NT+1];
   logic [W-1:0]  pending    [NT];
   logic [W-1:0]  grant      [NT];
   logic [W*W-1:0] op_slot   [NT];
   logic [NT-1:0] commit;

   generate
      if (ALLOW_SPLIT) begin : g_split
         assign sep_eff = thr_sep;
      end else begin : g_whole
         assign sep_eff = '0;
      end
   endgenerate

   assign eligible      = thr_valid & ~thr_stall;
   assign free_chain[0] = '1;

   generate
      for (genvar t = 0; t < NT; t++) begin : g_thr
         mtw_resid #(.W(W)) u_resid (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (thr_valid[t]),
            .opmask  (thr_opmask[t*W +: W]),
            .commit  (commit[t]),
            .grant   (grant[t]),
            .pending (pending[t]),
            .done    (thr_done[t]),
            .part    (thr_part[t])
         );
         mtw_thread_alloc #(.W(W), .TW(TW), .SLOT_MAP(SLOT_MAP)) u_alloc (
            .eligible (eligible[t]),
            .sep      (sep_eff[t]),
            .pending  (pending[t]),
            .optype   (thr_optype[t*W*TW +: W*TW]),
            .free_in  (free_chain[t]),
            .grant    (grant[t]),
            .op_slot  (op_slot[t]),
            .free_out (free_chain[t+1]),
            .commit   (commit[t])
         );
         AST_IDLE_THREAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !eligible[t] |-> (!thr_done[t] && !thr_part[t])); // R3
         AST_PART_ONLY_SEP: assert property (@(posedge clk) disable iff (!rst_n)
            thr_part[t] |-> sep_eff[t]); // R5
      end
   endgenerate

   // Slot mux: at most one thread/op claims each slot.
   logic [W-1:0]      b_valid;
   logic [W*PW-1:0]   b_pay;
   logic [W*TIDW-1:0] b_tid;
   logic [NT*W-1:0]   claim [W];

   always_comb begin
      b_valid = '0;
      b_pay   = '0;
      b_tid   = '0;
      for (int s = 0; s < W; s++) begin
         claim[s] = '0;
         for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < W; j++) begin
               if (op_slot[t][j*W + s]) begin
                  claim[s][t*W + j] = 1'b1;
                  b_valid[s]            = 1'b1;
                  b_pay[s*PW +: PW]     = thr_oppay[(t*W + j)*PW +: PW];
                  b_tid[s*TIDW +: TIDW] = TIDW'(t);
               end
            end
         end
      end
   end

   generate
      for (genvar s = 0; s < W; s++) begin : g_slot_chk
         AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(claim[s])); // R4
      end
   endgenerate

   mtw_bundle_reg #(.W(W), .PW(PW), .TIDW(TIDW)) u_bundle (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (b_valid),
      .d_pay   (b_pay),
      .d_tid   (b_tid),
      .q_valid (iss_valid),
      .q_pay   (iss_pay),
      .q_tid   (iss_tid)
   );
endmodule

// File: tb/mtw_issue_merger_test.sv
module mtw_issue_merger_test;
   localparam int NT = 4, W = 4, TW = 2, PW = 16, TIDW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0] thr_valid, thr_stall, thr_sep;
   logic [NT*W-1:0] thr_opmask;
   logic [NT*W*TW-1:0] thr_optype;
   logic [NT*W*PW-1:0] thr_oppay;
   logic [NT-1:0] thr_done, thr_part;
   logic [W-1:0] iss_valid;
   logic [W*PW-1:0] iss_pay;
   logic [W*TIDW-1:0] iss_tid;
   int checks = 0, failures = 0;

   always #4 clk = ~clk;

   mtw_issue_merger uut (
      .clk(clk), .rst_n(rst_n), .thr_valid(thr_valid), .thr_stall(thr_stall),
      .thr_sep(thr_sep), .thr_opmask(thr_opmask), .thr_optype(thr_optype),
      .thr_oppay(thr_oppay), .thr_done(thr_done), .thr_part(thr_part),
      .iss_valid(iss_valid), .iss_pay(iss_pay), .iss_tid(iss_tid)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_slot(string tag, int s, bit v, int tid, logic [15:0] pay);
      check({tag, " valid"}, 32'(iss_valid[s]), 32'(v));
      if (v) begin
         check({tag, " tid"}, 32'(iss_tid[s*TIDW +: TIDW]), 32'(tid));
         check({tag, " pay"}, 32'(iss_pay[s*PW +: PW]), 32'(pay));
      end
   endtask

   task automatic chk_ack(string tag, int t, bit d, bit p);
      check({tag, " done"}, 32'(thr_done[t]), 32'(d));
      check({tag, " part"}, 32'(thr_part[t]), 32'(p));
   endtask

   task automatic clear_in();
      thr_valid = '0; thr_stall = '0; thr_sep = '0;
      thr_opmask = '0; thr_optype = '0; thr_oppay = '0;
   endtask

   task automatic set_thr(int t, bit v, bit st, bit sp);
      thr_valid[t] = v; thr_stall[t] = st; thr_sep[t] = sp;
   endtask

   task automatic set_op(int t, int j, int ty, logic [15:0] pay);
      thr_opmask[t*W + j] = 1'b1;
      thr_optype[(t*W + j)*TW +: TW] = TW'(ty);
      thr_oppay[(t*W + j)*PW +: PW] = pay;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic idle();
      clear_in(); step();
   endtask

   task automatic t_reset();
      check("R9 reset bundle empty", 32'(iss_valid), 32'h0);
      check("R9 reset no done", 32'(thr_done), 32'h0);
   endtask

   task automatic t_main_alone();
      clear_in(); set_thr(0, 1, 0, 0);
      set_op(0, 0, 1, 16'hA000); set_op(0, 1, 0, 16'hA001);
      #1;
      chk_ack("R1 main done", 0, 1, 0);
      check("R8 bundle not yet updated", 32'(iss_valid), 32'h0);
      step();
      chk_slot("R4 R7 s0", 0, 1, 0, 16'hA001);
      chk_slot("R4 s1", 1, 0, 0, 0);
      chk_slot("R4 s2", 2, 1, 0, 16'hA000);
      chk_slot("R4 s3", 3, 0, 0, 0);
      idle();
   endtask

   task automatic t_fill_order();
      clear_in();
      set_thr(0, 1, 0, 0); set_op(0, 0, 0, 16'hB000);
      set_thr(1, 1, 0, 0); set_op(1, 0, 0, 16'hB100); set_op(1, 1, 2, 16'hB101);
      set_thr(2, 1, 0, 0); set_op(2, 0, 1, 16'hB200);
      set_thr(3, 1, 0, 0); set_op(3, 0, 1, 16'hB300);
      #1;
      chk_ack("R2 t0", 0, 1, 0); chk_ack("R2 t1", 1, 1, 0);
      chk_ack("R2 t2", 2, 1, 0); chk_ack("R2 t3 loses", 3, 0, 0);
      step();
      chk_slot("R2 s0", 0, 1, 0, 16'hB000);
      chk_slot("R2 s1", 1, 1, 1, 16'hB100);
      chk_slot("R2 s2", 2, 1, 2, 16'hB200);
      chk_slot("R2 R7 s3", 3, 1, 1, 16'hB101);
      idle();
   endtask

   task automatic t_main_stall();
      clear_in();
      set_thr(0, 1, 1, 0); set_op(0, 0, 0, 16'hC000); set_op(0, 1, 0, 16'hC001);
      set_thr(1, 1, 0, 0); set_op(1, 0, 0, 16'hC100); set_op(1, 1, 0, 16'hC101);
      #1;
      chk_ack("R3 stalled main", 0, 0, 0); chk_ack("R3 spec", 1, 1, 0);
      step();
      chk_slot("R3 s0", 0, 1, 1, 16'hC100);
      chk_slot("R3 s1", 1, 1, 1, 16'hC101);
      chk_slot("R3 s2", 2, 0, 0, 0);
      idle();
   endtask

   task automatic t_insep_wait();
      clear_in();
      set_thr(0, 1, 0, 0); set_op(0, 0, 1, 16'hD000);
      set_thr(1, 1, 0, 0); set_op(1, 0, 1, 16'hD100); set_op(1, 1, 0, 16'hD101);
      set_thr(2, 1, 0, 0); set_op(2, 0, 0, 16'hD200);
      #1;
      chk_ack("R5 insep waits", 1, 0, 0); chk_ack("R5 next thread", 2, 1, 0);
      step();
      chk_slot("R5 s0", 0, 1, 2, 16'hD200);
      chk_slot("R5 s1", 1, 0, 0, 0);
      chk_slot("R5 s2", 2, 1, 0, 16'hD000);
      chk_slot("R5 s3", 3, 0, 0, 0);
      // main needs three type-0 slots, only two exist
      clear_in();
      set_thr(0, 1, 0, 0);
      set_op(0, 0, 0, 16'hD010); set_op(0, 1, 0, 16'hD011); set_op(0, 2, 0, 16'hD012);
      set_thr(1, 1, 0, 0); set_op(1, 0, 0, 16'hD110);
      #1;
      chk_ack("R4 R5 main too wide", 0, 0, 0);
      step();
      chk_slot("R4 s0 to spec", 0, 1, 1, 16'hD110);
      chk_slot("R4 s1 empty", 1, 0, 0, 0);
      idle();
   endtask

   task automatic setup_split();
      clear_in();
      set_thr(0, 1, 0, 0); set_op(0, 0, 1, 16'hE000);
      set_thr(1, 1, 0, 1); set_op(1, 0, 1, 16'hE100); set_op(1, 1, 2, 16'hE101);
   endtask

   task automatic t_split();
      setup_split(); #1;
      chk_ack("R6 partial", 1, 0, 1);
      step();
      chk_slot("R6 first s2", 2, 1, 0, 16'hE000);
      chk_slot("R6 first s3", 3, 1, 1, 16'hE101);
      thr_valid[0] = 1'b0; thr_opmask[3:0] = '0; #1;
      chk_ack("R6 rest done", 1, 1, 0);
      step();
      chk_slot("R6 rest s2", 2, 1, 1, 16'hE100);
      chk_slot("R6 no reissue s3", 3, 0, 0, 0);
      idle();
   endtask

   task automatic t_squash();
      setup_split(); step();
      thr_valid[1] = 1'b0; step();
      setup_split(); thr_valid[0] = 1'b0; thr_opmask[3:0] = '0; #1;
      chk_ack("R10 whole after squash", 1, 1, 0);
      step();
      chk_slot("R10 s2", 2, 1, 1, 16'hE100);
      chk_slot("R10 s3", 3, 1, 1, 16'hE101);
      idle();
   endtask

   task automatic t_reset_resid();
      setup_split(); step();
      rst_n = 1'b0; #1;
      check("R9 bundle cleared", 32'(iss_valid), 32'h0);
      step(); rst_n = 1'b1;
      setup_split(); thr_valid[0] = 1'b0; thr_opmask[3:0] = '0; #1;
      chk_ack("R9 whole after reset", 1, 1, 0);
      step();
      chk_slot("R9 s3", 3, 1, 1, 16'hE101);
      idle();
   endtask

   task automatic t_empty();
      clear_in(); set_thr(2, 1, 0, 0); #1;
      chk_ack("R11 empty done", 2, 1, 0);
      step();
      check("R11 no slots", 32'(iss_valid), 32'h0);
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      clear_in();
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_main_alone();
      t_fill_order();
      t_main_stall();
      t_insep_wait();
      t_split();
      t_squash();
      t_reset_resid();
      t_empty();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule